// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This peripheral produces a requested number of configuration clock pulses on a single output and then raises a completion flag. A host on a 32-bit register bus writes a pulse count to one register; the block immediately starts toggling its clock output, one cycle high and one cycle low per pulse, until exactly that many pulses have gone out. It then sets a sticky done bit in a status register. The host clears done by writing a one to it, both before arming a burst and again once it has seen done.

The sequencer has three named states. `ST_IDLE` waits for a count write. Transition *arm* (`ST_IDLE` to `ST_HIGH`) happens on a count write with a non-zero value. `ST_HIGH` drives the clock high for one cycle and always takes transition *fall* to `ST_LOW`. `ST_LOW` drives the clock low. If pulses remain, it takes transition *again* back to `ST_HIGH`. On the last pulse it takes transition *finish* to `ST_IDLE`, and done is set on that edge. A zero count never leaves `ST_IDLE` and sets done straight away.

Reads are combinational views of the live registers and are never cached.

Top module: `cfg_clk_burst`

## Requirements
- R1: After reset, `dclk` is 0, the count register reads 0 and the status register reads 0.
- R2: A write of N (N ≥ 1) to the count register at byte offset 0x08 while idle produces exactly N pulses on `dclk`. Each pulse is high for one clock cycle and then low for one clock cycle. The first high cycle is the cycle right after the write edge.
- R3: Done (status bit 0) is set on the clock edge 2N cycles after the accepted count write. On that same edge the last low cycle ends.
- R4: Done stays set until a status write (byte offset 0x0c) with bit 0 equal to 1. A status write with bit 0 equal to 0 leaves done unchanged.
- R5: A count write of 0 while idle produces no pulse and sets done on the write edge.
- R6: A count write is ignored while a burst runs, including on the burst's final edge. The pulse total and the count readback are unchanged.
- R7: The count register is CNT_W = 16 bits wide. It reads back the last accepted count in bits 15:0, with the upper bits 0. Status reads return done in bit 0 and 0 elsewhere. Any other address reads 0.
- R8: Writes to any address other than 0x08 and 0x0c have no effect.
- R9: When a burst finishes on the same edge as a done-clear write, done ends up set.
- R10: A count write while done is still set (not yet cleared) is accepted and starts a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, live |
| dclk | output | 1 | Configuration clock pulse output |

## Verification
The hardest situations to reach are the ones that depend on the exact edge where a burst finishes. One is a count write that lands on that final edge, which must still be refused. The other is a done-clear write that lands there, which must lose to the set. The stimulus counts cycles from the accepted write and places the second write on edge 2N. It also places a write on edge 2N+1, the first edge where a write is accepted again. A behavioural queue model of the expected clock stream is compared against `dclk` and the read data on every cycle, so any slip of one edge shows up.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
    localparam int unsigned CNT_OFS  = 32'h08;
    localparam int unsigned STAT_OFS = 32'h0c;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/cbg_regs.sv
module cbg_regs
    import cbg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              burst_end,
    output logic              start,
    output logic [CNT_W-1:0]  start_cnt,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [CNT_W-1:0]  cnt_rb
);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    logic hit_cnt, hit_stat, clr_req, set_req;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata;
    assign hit_cnt   = bus_wr && (bus_addr == A_CNT);
    assign hit_stat  = bus_wr && (bus_addr == A_STAT);
    assign start     = hit_cnt && !busy;
    assign start_cnt = bus_wdata[CNT_W-1:0];
    assign clr_req   = hit_stat && bus_wdata[0];
    // a zero count completes at once; a finished burst completes on its last edge
    assign set_req   = burst_end || (start && (start_cnt == '0));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_rb <= '0;
            done   <= 1'b0;
        end else begin
            if (start) cnt_rb <= start_cnt;
            if (set_req)      done <= 1'b1;
            else if (clr_req) done <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CNT)       bus_rdata = DATA_W'(cnt_rb);
        else if (bus_addr == A_STAT) bus_rdata = DATA_W'(done);
    end
endmodule

// File: rtl/cbg_seq.sv
module cbg_seq
    import cbg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    output logic             busy,
    output logic             burst_end,
    output logic             dclk
);
    seq_state_t      state_q, state_d;
    logic [CNT_W-1:0] rem_q, rem_d;
    logic             last;

    assign last = (rem_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_IDLE: if (start && (start_cnt != '0)) begin   // arm
                state_d = ST_HIGH;
                rem_d   = start_cnt;
            end
            ST_HIGH: state_d = ST_LOW;                        // fall
            ST_LOW: begin
                if (last) begin                               // finish
                    state_d = ST_IDLE;
                    rem_d   = '0;
                end else begin                                // again
                    state_d = ST_HIGH;
                    rem_d   = rem_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        dclk      = (state_q == ST_HIGH);
        busy      = (state_q != ST_IDLE);
        burst_end = (state_q == ST_LOW) && last;
    end
endmodule

// File: rtl/cfg_clk_burst.sv
module cfg_clk_burst #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dclk
);
    logic             start_w, busy_w, end_w, done_w;
    logic [CNT_W-1:0] start_cnt_w, cnt_rb_w;

    cbg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .busy(busy_w), .burst_end(end_w),
        .start(start_w), .start_cnt(start_cnt_w), .bus_rdata(bus_rdata),
        .done(done_w), .cnt_rb(cnt_rb_w)
    );

    cbg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_w), .start_cnt(start_cnt_w),
        .busy(busy_w), .burst_end(end_w), .dclk(dclk)
    );
endmodule

// File: rtl/cbg_chk.sv
module cbg_chk
    import cbg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              dclk,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  cnt_rb
);
    logic unused_chk;
    logic wcnt, wclr;
    assign unused_chk = ^bus_wdata;
    assign wcnt = bus_wr && (bus_addr == ADDR_W'(CNT_OFS));
    assign wclr = bus_wr && (bus_addr == ADDR_W'(STAT_OFS)) && bus_wdata[0];

    assert_high_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dclk |=> !dclk);
    assert_pulse_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dclk |-> busy);
    assert_first_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt && !busy && (bus_wdata[CNT_W-1:0] != '0)) |=> dclk);
    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wclr) |=> done);
    assert_done_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wclr && !busy) |=> !done);
    assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt && !busy && (bus_wdata[CNT_W-1:0] == '0)) |=> (done && !dclk && !busy));
    assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt && busy) |=> $stable(cnt_rb));
endmodule

bind cfg_clk_burst cbg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .dclk(dclk), .busy(busy_w), .done(done_w),
    .cnt_rb(cnt_rb_w)
);

// File: tb/sim_cfg_clk_burst.sv
`timescale 1ns/1ps
module sim_cfg_clk_burst;
    localparam int A_CNT = 8'h08, A_STAT = 8'h0c;

    logic        clk = 0, rst_n = 0, bus_wr = 0, dclk;
    logic [7:0]  bus_addr = 8'h0c;
    logic [31:0] bus_wdata = 0, bus_rdata;
    int compared = 0, mismatched = 0, pulses = 0;
    string tag = "R1";
    bit finished = 0;

    // reference model state
    bit q[$];
    bit m_busy = 0, m_dclk = 0, m_done = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    cfg_clk_burst u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dclk(dclk));

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_busy = 0; m_dclk = 0; m_done = 0; m_cnt = 0;
        end else begin
            bit was_busy, acc, clr, set;
            int n;
            was_busy = m_busy;
            acc = bus_wr && bus_addr == A_CNT && !was_busy;
            clr = bus_wr && bus_addr == A_STAT && bus_wdata[0];
            set = 0;
            if (m_busy && q.size() == 0) begin m_busy = 0; set = 1; m_dclk = 0; end
            else if (q.size() > 0) m_dclk = q.pop_front();
            else m_dclk = 0;
            if (acc) begin
                n = int'(bus_wdata[15:0]);
                m_cnt = n;
                if (n == 0) set = 1;
                else begin
                    for (int i = 0; i < n; i++) begin q.push_back(1); q.push_back(0); end
                    m_dclk = q.pop_front();
                    m_busy = 1;
                end
            end
            if (set) m_done = 1; else if (clr) m_done = 0;
        end
    end

    // every-cycle comparison, sampled between edges
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            logic [31:0] exp;
            chk({tag, " dclk"}, {31'b0, dclk}, {31'b0, m_dclk});
            if (dclk) pulses++;
            exp = (bus_addr == A_CNT) ? m_cnt : (bus_addr == A_STAT) ? {31'b0, m_done} : 0;
            chk({tag, " rdata"}, bus_rdata, exp);
        end
    end

    task automatic drive_now(int a, logic [31:0] d);
        bus_addr = a[7:0]; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0; bus_addr = A_STAT[7:0];
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        drive_now(a, d);
    endtask

    task automatic rd(int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a[7:0];
        #1 v = bus_rdata;
    endtask

    task automatic burst(string t, int n);
        logic [31:0] v;
        tag = t;
        wr(A_STAT, 1);
        pulses = 0;
        wr(A_CNT, n);
        repeat (2 * n + 2) @(negedge clk);
        chk({t, " pulse total"}, pulses, n);
        rd(A_STAT, v);
        chk({t, " done after burst"}, v, 1);
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R1 dclk in reset", {31'b0, dclk}, 0);
        rst_n = 1;
        rd(A_CNT, v);  chk("R1 count after reset", v, 0);
        rd(A_STAT, v); chk("R1 status after reset", v, 0);

        burst("R2 R3", 5);
        burst("R2 R3", 1);

        // R4: zero write leaves done, one write clears it
        tag = "R4";
        wr(A_STAT, 32'hFFFF_FFFE); rd(A_STAT, v); chk("R4 done kept", v, 1);
        wr(A_STAT, 1);             rd(A_STAT, v); chk("R4 done cleared", v, 0);

        // R5: zero count
        tag = "R5"; pulses = 0;
        wr(A_CNT, 0); rd(A_STAT, v); chk("R5 zero done", v, 1);
        chk("R5 zero pulses", pulses, 0);

        // R6: write mid-burst ignored
        tag = "R6"; wr(A_STAT, 1); pulses = 0;
        wr(A_CNT, 20); repeat (6) @(negedge clk); drive_now(A_CNT, 3);
        rd(A_CNT, v); chk("R6 readback kept", v, 20);
        repeat (40) @(negedge clk);
        chk("R6 pulse total", pulses, 20);

        // R6: write on the finishing edge refused, next edge accepted
        tag = "R6 R10"; pulses = 0;
        wr(A_CNT, 4); repeat (7) @(negedge clk);
        drive_now(A_CNT, 9);   // lands on edge 2N: ignored
        drive_now(A_CNT, 2);   // lands on edge 2N+1 with done set: accepted
        repeat (8) @(negedge clk);
        chk("R6 R10 pulse total", pulses, 6);
        rd(A_CNT, v); chk("R10 readback", v, 2);

        // R9: clear on the same edge the burst finishes
        tag = "R9"; wr(A_STAT, 1);
        wr(A_CNT, 2); repeat (3) @(negedge clk);
        drive_now(A_STAT, 1);
        rd(A_STAT, v); chk("R9 set wins", v, 1);

        // R8: other addresses
        tag = "R8";
        wr(8'h04, 7); wr(8'h10, 1); wr(8'h0c + 8'h20, 1);
        rd(A_STAT, v); chk("R8 status untouched", v, 1);
        rd(A_CNT, v);  chk("R8 count untouched", v, 2);
        rd(8'h04, v);  chk("R7 unmapped reads zero", v, 0);

        // R7: truncation to 16 bits
        tag = "R7"; wr(A_STAT, 1); pulses = 0;
        wr(A_CNT, 32'h0001_0123);
        rd(A_CNT, v); chk("R7 readback truncated", v, 32'h0123);
        repeat (2 * 32'h123 + 2) @(negedge clk);
        chk("R7 pulse total", pulses, 32'h123);

        burst("R2 R3 typical", 256);
        burst("R2 R3 typical", 32'h7ff);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule